// File: doc/BRIEF.md
# CAS Latency Read Data Pipeline

This block sits between a memory array's column read path and the DQ pins of a synchronous DRAM device. When a read command is registered, it produces one beat request per clock for the programmed burst length. It accepts the array's data for each beat and delays that data by the programmed read latency of two or three clocks. It drives an output-enable that opens one clock ahead of the first valid beat and closes after the last one.

The latency comes from a three-bit mode field. Two codes are legal. Any other code raises an error flag, and reads are then refused until a legal code is written. A new latency is taken only while no read is in flight, so a burst never sees its timing change part way through. A new read that arrives while a burst is still generating beats restarts the burst. A read issued exactly one burst length after the previous one continues the data stream with no gap.

Top module: `cl_read_pipe`

## Requirements
- R1: After reset, dq_oe, dq_valid, arr_req and cl_err are low and dq_out is zero. The latency is 2 clocks.
- R2: With latency code 3'b010 (latency 2), a read sampled at edge n gives the first dq_valid beat after edge n+2.
- R3: With latency code 3'b011 (latency 3), a read sampled at edge n gives the first dq_valid beat after edge n+3.
- R4: dq_oe rises exactly one clock before the first dq_valid beat of a burst.
- R5: The burst code rd_bl selects the number of consecutive beats: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8. The beats carry the array data in the order the array delivered it.
- R6: dq_oe stays high through the last valid beat and falls on the next clock when no further data follows. dq_oe falls only right after a valid beat.
- R7: A read sampled exactly BL clocks after the previous one gives continuous dq_valid and dq_oe across both bursts.
- R8: Writing a latency code other than 3'b010 or 3'b011 sets cl_err. While cl_err is high, reads produce no arr_req, no dq_oe and no dq_valid.
- R9: A latency write is ignored while a read is pending, generating beats, or moving through the delay stages. The setting in force stays unchanged.
- R10: dq_out is zero in every cycle where dq_valid is low.
- R11: arr_req is high for BL cycles, starting in the cycle after the read is sampled. The array presents each beat's data during its arr_req cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we | input | 1 | Latency field write strobe |
| mode_cl | input | 3 | Latency field value (3'b010 = 2, 3'b011 = 3) |
| rd_cmd | input | 1 | Read command strobe |
| rd_bl | input | 2 | Burst length code for this read |
| arr_req | output | 1 | Beat request to the array, one per beat |
| arr_data | input | DATA_W | Array data for the requested beat |
| dq_oe | output | 1 | DQ output-driver enable |
| dq_out | output | DATA_W | DQ output data |
| dq_valid | output | 1 | DQ data valid for this clock |
| cl_err | output | 1 | Illegal latency code is programmed |

## Verification
The assertions check several rules on every cycle: dq_oe leads the first valid beat and closes only after a valid beat, dq_out stays at zero outside valid beats, the error state keeps the pipeline silent, and the latency setting holds while data is in flight. Beat requests are also checked to start only from a read. The exact latency counts, the number of beats for each burst code, the data order and gapless back-to-back reads need whole-burst scenarios, so the bench's directed tests cover them. The bench also shows that a latency write issued during a burst leaves the setting in force unchanged.

// File: rtl/cl_pipe_pkg.sv
// Package: shared constants, config type and decode for the read latency pipe.
// Assumes only latency values 2 and 3 are legal; all other codes are errors.
package cl_pipe_pkg;

    localparam int CL_FIELD_W = 3;
    localparam int MIN_CL     = 2;
    localparam int MAX_CL     = 3;
    localparam int LAT_W      = $clog2(MAX_CL + 1);

    localparam logic [CL_FIELD_W-1:0] CODE_CL2 = 3'b010;
    localparam logic [CL_FIELD_W-1:0] CODE_CL3 = 3'b011;

    typedef struct packed {
        logic             legal;
        logic [LAT_W-1:0] lat;
    } lat_cfg_t;

    // Map a raw field value to a latency setting; illegal codes keep lat at MIN_CL.
    function automatic lat_cfg_t decode_cl(input logic [CL_FIELD_W-1:0] code);
        lat_cfg_t r;
        r.legal = 1'b0;
        r.lat   = LAT_W'(MIN_CL);
        if (code == CODE_CL2) begin
            r.legal = 1'b1;
            r.lat   = LAT_W'(2);
        end else if (code == CODE_CL3) begin
            r.legal = 1'b1;
            r.lat   = LAT_W'(3);
        end
        return r;
    endfunction

endpackage

// File: rtl/cl_latency_cfg.sv
// Module: holds the programmed read latency and the illegal-code flag.
// Assumes the caller asserts busy for the whole time a read is in flight;
// a write offered while busy is dropped.
module cl_latency_cfg
    import cl_pipe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CL_FIELD_W-1:0] wr_code,
    input  logic                  busy,
    output logic [LAT_W-1:0]      lat,
    output logic                  err
);

    lat_cfg_t cfg_q;
    lat_cfg_t cfg_next;

    // Decode the offered code.
    always_comb cfg_next = decode_cl(wr_code);

    // Register the setting; reset to latency 2, accept writes only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.legal <= 1'b1;
            cfg_q.lat   <= LAT_W'(MIN_CL);
        end else if (wr_en && !busy) begin
            cfg_q <= cfg_next;
        end
    end

    assign lat = cfg_q.lat;
    assign err = ~cfg_q.legal;

endmodule

// File: rtl/cl_beat_gen.sv
// Module: turns an accepted read into BL consecutive beat tokens.
// Assumes the burst code selects 2**code beats; a new read restarts the count,
// so a read that lands exactly as a burst ends continues without a gap.
module cl_beat_gen #(
    parameter int BL_CODE_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [BL_CODE_W-1:0] bl_code,
    output logic                 beat,
    output logic                 active
);

    localparam int MAX_BL = 1 << ((1 << BL_CODE_W) - 1);
    localparam int CNT_W  = (MAX_BL > 1) ? $clog2(MAX_BL) : 1;

    logic [CNT_W-1:0] remain_q;
    logic [CNT_W:0]   bl_len;

    // Burst length from its code.
    always_comb bl_len = (CNT_W + 1)'(1) << bl_code;

    // Count down the beats left in the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat     <= 1'b0;
            remain_q <= '0;
        end else if (start) begin
            beat     <= 1'b1;
            remain_q <= CNT_W'(bl_len - 1'b1);
        end else if (remain_q != '0) begin
            beat     <= 1'b1;
            remain_q <= remain_q - 1'b1;
        end else begin
            beat     <= 1'b0;
        end
    end

    assign active = beat;

endmodule

// File: rtl/cl_delay_line.sv
// Module: delays beat tokens and their data by the selected latency.
// Stage 0 is the beat token itself; the enable taps stage lat-1 or lat and
// the valid flag taps stage lat. Assumes lat stays within MIN_CL..DEPTH.
module cl_delay_line #(
    parameter int DEPTH  = 3,
    parameter int DATA_W = 16,
    parameter int LAT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [LAT_W-1:0]  lat,
    output logic              oe,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    output logic              busy
);

    logic [DEPTH:0]    tok;
    logic [DATA_W-1:0] dat [DEPTH+1];

    assign tok[0] = tok_in;
    assign dat[0] = data_in;

    for (genvar s = 1; s <= DEPTH; s++) begin : g_stage
        // One pipeline stage: advance the token and its beat data.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tok[s] <= 1'b0;
                dat[s] <= '0;
            end else begin
                tok[s] <= tok[s-1];
                dat[s] <= tok[s-1] ? dat[s-1] : '0;
            end
        end
    end

    // Select the taps for the current latency.
    always_comb begin
        valid = 1'b0;
        oe    = 1'b0;
        data  = '0;
        for (int s = 1; s <= DEPTH; s++) begin
            if (LAT_W'(s) == lat) begin
                valid = tok[s];
                oe    = tok[s] | tok[s-1];
                data  = tok[s] ? dat[s] : '0;
            end
        end
    end

    // Any token still inside the line.
    always_comb busy = |tok[DEPTH:1];

endmodule

// File: rtl/cl_read_pipe.sv
// Module: top of the read latency pipeline.
// Accepts reads (refused while an illegal latency is set), generates beat
// requests to the array and returns the data on DQ after the programmed latency.
// Assumes the array presents each beat's data in the cycle arr_req is high.
module cl_read_pipe
    import cl_pipe_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int BL_CODE_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_we,
    input  logic [CL_FIELD_W-1:0] mode_cl,
    input  logic                  rd_cmd,
    input  logic [BL_CODE_W-1:0]  rd_bl,
    output logic                  arr_req,
    input  logic [DATA_W-1:0]     arr_data,
    output logic                  dq_oe,
    output logic [DATA_W-1:0]     dq_out,
    output logic                  dq_valid,
    output logic                  cl_err
);

    logic [LAT_W-1:0] lat_sel;
    logic             rd_go;
    logic             gen_active;
    logic             line_busy;
    logic             in_flight;

    // A read is accepted only when the latency setting is legal.
    always_comb rd_go = rd_cmd & ~cl_err;

    // Anything pending or moving blocks a latency change.
    always_comb in_flight = rd_cmd | gen_active | line_busy;

    cl_latency_cfg i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_we),
        .wr_code (mode_cl),
        .busy    (in_flight),
        .lat     (lat_sel),
        .err     (cl_err)
    );

    cl_beat_gen #(
        .BL_CODE_W (BL_CODE_W)
    ) i_beats (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (rd_go),
        .bl_code (rd_bl),
        .beat    (arr_req),
        .active  (gen_active)
    );

    cl_delay_line #(
        .DEPTH  (MAX_CL),
        .DATA_W (DATA_W),
        .LAT_W  (LAT_W)
    ) i_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .tok_in  (arr_req),
        .data_in (arr_data),
        .lat     (lat_sel),
        .oe      (dq_oe),
        .valid   (dq_valid),
        .data    (dq_out),
        .busy    (line_busy)
    );

endmodule

// File: rtl/cl_read_pipe_chk.sv
// Checker: cycle-level rules of the read latency pipeline, bound to the top.
module cl_read_pipe_chk #(
    parameter int DATA_W = 16,
    parameter int LAT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_cmd,
    input logic              arr_req,
    input logic              dq_oe,
    input logic              dq_valid,
    input logic [DATA_W-1:0] dq_out,
    input logic              cl_err,
    input logic [LAT_W-1:0]  lat_sel
);

    // R4: a burst's first valid beat follows an enabled cycle
    assert_oe_leads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_valid) |-> $past(dq_oe));

    // R6: enable covers every valid beat and closes only after one
    assert_oe_covers_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid |-> dq_oe);
    assert_oe_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe) |-> $past(dq_valid));

    // R10: no data outside valid beats
    assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_valid |-> (dq_out == '0));

    // R8: illegal latency keeps the pipe silent
    assert_err_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cl_err |-> (!arr_req && !dq_oe && !dq_valid));

    // R9: latency holds while data is moving
    assert_lat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req || dq_oe) |=> $stable(lat_sel));

    // R11: beat requests start only from a read
    assert_req_from_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_req) |-> $past(rd_cmd));

endmodule

bind cl_read_pipe cl_read_pipe_chk #(
    .DATA_W (DATA_W),
    .LAT_W  (cl_pipe_pkg::LAT_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_cmd   (rd_cmd),
    .arr_req  (arr_req),
    .dq_oe    (dq_oe),
    .dq_valid (dq_valid),
    .dq_out   (dq_out),
    .cl_err   (cl_err),
    .lat_sel  (lat_sel)
);

// File: tb/test_cl_read_pipe.sv
// Directed bench for cl_read_pipe: one task per scenario, each checks itself.
module test_cl_read_pipe;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_we = 1'b0;
    logic [2:0]    mode_cl = 3'b010;
    logic          rd_cmd = 1'b0;
    logic [1:0]    rd_bl = 2'b00;
    logic          arr_req;
    logic [DW-1:0] arr_data = '0;
    logic          dq_oe;
    logic [DW-1:0] dq_out;
    logic          dq_valid;
    logic          cl_err;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    cl_read_pipe #(.DATA_W(DW), .BL_CODE_W(2)) i_cl_read_pipe (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_cl(mode_cl),
        .rd_cmd(rd_cmd), .rd_bl(rd_bl), .arr_req(arr_req), .arr_data(arr_data),
        .dq_oe(dq_oe), .dq_out(dq_out), .dq_valid(dq_valid), .cl_err(cl_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dq_oe == 0,    "R1", "dq_oe", dq_oe, 0);
        check(dq_valid == 0, "R1", "dq_valid", dq_valid, 0);
        check(arr_req == 0,  "R1", "arr_req", arr_req, 0);
        check(cl_err == 0,   "R1", "cl_err", cl_err, 0);
        check(dq_out == 0,   "R1", "dq_out", dq_out, 0);
    endtask

    task automatic t_mode(input logic [2:0] code, input bit exp_err, input string req);
        @(negedge clk);
        mode_we = 1'b1;
        mode_cl = code;
        @(negedge clk);
        mode_we = 1'b0;
        check(cl_err == exp_err, req, "cl_err after write", cl_err, exp_err);
    endtask

    // Issue a read (optionally a second one BL cycles later), feed beat data
    // and compare every output cycle against the latency/burst rules.
    task automatic t_read(input int lat, input logic [1:0] blc, input bit twice,
                          input bit refused, input bit poke, input logic [DW-1:0] seed,
                          input string req);
        int bl = 1 << blc;
        int tot = twice ? 2 * bl : bl;
        bit e_oe, e_val, e_req;
        logic [DW-1:0] e_dat;
        bit err_before = cl_err;
        rd_bl  = blc;
        rd_cmd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_cmd = 1'b0;
        for (int t = 0; t < 24; t++) begin
            e_req = !refused && (t < tot);
            e_val = !refused && (t >= lat) && (t < lat + tot);
            e_oe  = !refused && (t >= lat - 1) && (t < lat + tot);
            e_dat = e_val ? DW'(seed + DW'(t - lat)) : '0;
            check(arr_req == e_req,  (t == 0) ? "R11" : req, $sformatf("arr_req t=%0d", t), arr_req, e_req);
            check(dq_valid == e_val, (t == lat) ? ((lat == 2) ? "R2" : "R3") : req,
                  $sformatf("dq_valid t=%0d", t), dq_valid, e_val);
            check(dq_oe == e_oe, (t == lat - 1) ? "R4" : ((t == lat + tot) ? "R6" : req),
                  $sformatf("dq_oe t=%0d", t), dq_oe, e_oe);
            check(dq_out == e_dat, e_val ? "R5" : "R10", $sformatf("dq_out t=%0d", t), dq_out, e_dat);
            arr_data = DW'(seed + DW'(t));
            if (twice && t == bl - 1) rd_cmd = 1'b1;
            if (twice && t == bl)     rd_cmd = 1'b0;
            if (poke && t == 2) begin mode_we = 1'b1; mode_cl = 3'b011; end
            if (poke && t == 3) mode_we = 1'b0;
            @(negedge clk);
        end
        check(cl_err == err_before, req, "cl_err unchanged by read", cl_err, err_before);
    endtask

    initial begin
        t_reset();
        t_read(2, 2'b11, 0, 0, 0, 16'h1000, "R1");     // default latency 2
        t_read(2, 2'b00, 0, 0, 0, 16'h1100, "R5");
        t_read(2, 2'b01, 0, 0, 0, 16'h1200, "R5");
        t_read(2, 2'b10, 0, 0, 0, 16'h1300, "R2");
        t_mode(3'b011, 0, "R3");
        t_read(3, 2'b00, 0, 0, 0, 16'h2000, "R3");
        t_read(3, 2'b01, 0, 0, 0, 16'h2100, "R5");
        t_read(3, 2'b10, 0, 0, 0, 16'h2200, "R5");
        t_read(3, 2'b11, 0, 0, 0, 16'h2300, "R3");
        t_read(3, 2'b10, 1, 0, 0, 16'h2400, "R7");     // gapless pair
        t_mode(3'b010, 0, "R2");
        t_read(2, 2'b01, 1, 0, 0, 16'h3000, "R7");
        t_read(2, 2'b11, 1, 0, 0, 16'h3100, "R7");
        t_read(2, 2'b00, 1, 0, 0, 16'h3200, "R7");
        t_read(2, 2'b11, 0, 0, 1, 16'h4000, "R9");     // write during burst
        t_read(2, 2'b10, 0, 0, 0, 16'h4100, "R9");     // still latency 2
        t_mode(3'b111, 1, "R8");
        t_read(2, 2'b11, 0, 1, 0, 16'h5000, "R8");
        t_mode(3'b000, 1, "R8");
        t_mode(3'b011, 0, "R8");
        t_read(3, 2'b01, 0, 0, 0, 16'h6000, "R8");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule